// File: doc/BRIEF.md
# Serial Sign-Extending Audio Attenuator

This block sits inline on a two-channel serial audio link that follows the I2S format, and it applies a fixed, coarse cut to both channels. Each channel slot is 32 bit clocks long. A 16-bit two's-complement sample is sent MSB first, one bit clock after the word-select edge, and the rest of the slot is zero padding. The block never turns the stream into parallel words and never multiplies. It delays the serial data by a few bit clocks and repeats the sign bit in the freed positions. The sample therefore moves toward the LSB end of the slot while its two's-complement value stays valid. Each bit position of shift lowers the level by about 6 dB. The default shift is two positions, which gives 12 dB.

A short word-select delay line tells the block how many bit clocks have passed since the last word-select edge. From that count it picks which data tap drives the output. Directly after an edge it picks the undelayed data, so the sign bit goes out in its usual slot position. It keeps repeating that sign bit while the older taps still hold bits from the previous slot. Once the slot is settled it switches to the most delayed tap. Word select goes downstream unchanged, so the downstream receiver keeps the original frame timing. The two lowest sample bits move into the padding area, where a receiver that takes at least 18 bits still uses them.

Top module: `i2s_attn`

## Requirements
- R1: `wsOut` equals `wsIn` at all times. It is not delayed or changed by the block.
- R2: In the first bit clock after a word-select edge, which carries the sample MSB, `sdOut` equals `sdIn`. The MSB keeps its slot position.
- R3: For shift count N (default 2), slot positions 1 to N+1 all carry the sample's sign bit. Position 0 is the bit clock in which word select has its new value. The sign bit appears N+1 times in total.
- R4: From slot position N+2 to the end of the slot, `sdOut` is `sdIn` delayed by exactly N bit clocks. Sample bit 14 appears at position N+2, and sample bit 0 appears at position 16+N.
- R5: A negative sample is extended with ones and a positive or zero sample is extended with zeros. As an example, 0x8000 comes out as 18 bits 11_1000_0000_0000_0000, followed by zeros.
- R6: In slot position 0 `sdOut` equals the undelayed `sdIn`, which is the last padding bit of the previous slot. With zero padding on the input, every output position after 16+N is zero.
- R7: Left slots (`wsIn` = 0) and right slots (`wsIn` = 1) are treated the same way. Tap selection depends only on the time since the last word-select edge.
- R8: A synchronous active-high `rst` clears every delay register to zero. In the first bit clocks after reset, with `wsIn` held at 0, `sdOut` shows the cleared delay stage and not earlier data.
- R9: Taken as a 32-bit word, each output slot equals the input slot word arithmetically shifted right by N. The output is that value placed one bit clock after the word-select edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock. All delay stages capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the delay stages |
| wsIn | input | 1 | Incoming word select (0 = left slot, 1 = right slot) |
| sdIn | input | 1 | Incoming serial data, MSB first, one bit clock after word-select edge |
| wsOut | output | 1 | Outgoing word select, identical to `wsIn` |
| sdOut | output | 1 | Attenuated serial data, sign-extended by the shift count |

## Verification
The bench builds the block with the default shift of two positions and with 32-bit slots that carry 16-bit samples. At this size one pass over 1024 upper-bit codes is short. The sweep is combined with walking-one and walking-zero patterns and with the extreme values 0x7FFF, 0x8000, 0xFFFF and 0x0000. Because the slots alternate between left and right, every word-select polarity and every sign of sample is seen. Each output slot is compared with a value computed as an arithmetic right shift, so each of the sign-hold positions and the delayed-magnitude boundary is checked bit by bit.

// File: rtl/i2s_attn_pkg.sv
package i2s_attn_pkg;

  // Number of bit positions the sample is moved toward the LSB (6 dB each).
  localparam int unsigned SHIFT_BITS = 2;

  // Word-select taps needed to see SHIFT_BITS+1 clocks past an edge.
  localparam int unsigned WS_TAPS    = SHIFT_BITS + 1;

  // Data delay stages; the deepest one feeds the settled part of the slot.
  localparam int unsigned DATA_TAPS  = SHIFT_BITS;

  // Strobes from the control to the datapath: one-hot choice of data tap.
  typedef struct packed {
    logic [SHIFT_BITS:0] tapSel;
  } tapStrobe_t;

endpackage

// File: rtl/i2s_attn_ctrl.sv
module i2s_attn_ctrl
  import i2s_attn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wsIn,
  output tapStrobe_t strobe
);

  // wsTap[k-1] holds word select as it was k bit clocks ago.
  logic [WS_TAPS-1:0] wsTap;
  logic [WS_TAPS:0]   wsAll;

  assign wsAll = {wsTap, wsIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      wsTap <= '0;
    end else begin
      wsTap <= wsAll[WS_TAPS-1:0];
    end
  end

  // agreeExt[k] is set when the word select of k clocks ago equals the current one.
  // The extra top bit is held low so the deepest tap closes the chain evenly.
  logic [WS_TAPS+1:2] agreeExt;

  genvar k;
  generate
    for (k = 2; k <= WS_TAPS; k++) begin : g_agree
      assign agreeExt[k] = (wsAll[k] == wsIn);
    end
  endgenerate
  assign agreeExt[WS_TAPS+1] = 1'b0;

  // The run of agreeing taps gives the age of the current slot.
  // Taps are taken in priority order, so exactly one select bit is set.
  always_comb begin
    logic run;
    strobe.tapSel    = '0;
    strobe.tapSel[0] = ~agreeExt[2];
    run = 1'b1;
    for (int j = 1; j <= int'(SHIFT_BITS); j++) begin
      run = run & agreeExt[j+1];
      strobe.tapSel[j] = run & ~agreeExt[j+2];
    end
  end

endmodule

// File: rtl/i2s_attn_datapath.sv
module i2s_attn_datapath
  import i2s_attn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sdIn,
  input  tapStrobe_t strobe,
  output logic       sdOut
);

  // dReg[k-1] holds serial data as it was k bit clocks ago.
  logic [DATA_TAPS-1:0] dReg;
  logic [DATA_TAPS:0]   tap;

  assign tap = {dReg, sdIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      dReg <= '0;
    end else begin
      dReg <= tap[DATA_TAPS-1:0];
    end
  end

  // AND-OR mux driven by the one-hot strobe from the control.
  assign sdOut = |(tap & strobe.tapSel);

endmodule

// File: rtl/i2s_attn.sv
module i2s_attn
  import i2s_attn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wsIn,
  input  logic sdIn,
  output logic wsOut,
  output logic sdOut
);

  tapStrobe_t strobe;

  i2s_attn_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wsIn   (wsIn),
    .strobe (strobe)
  );

  i2s_attn_datapath data_i (
    .clk    (clk),
    .rst    (rst),
    .sdIn   (sdIn),
    .strobe (strobe),
    .sdOut  (sdOut)
  );

  // Frame timing goes downstream untouched.
  assign wsOut = wsIn;

endmodule

// File: rtl/i2s_attn_chk.sv
module i2s_attn_chk
  import i2s_attn_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wsIn,
  input logic       sdIn,
  input logic       sdOut,
  input tapStrobe_t strobe
);

  localparam int unsigned AGE_MAX = SHIFT_BITS + 2;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);

  logic                  prevWs;
  logic                  armed;
  logic [AGE_W-1:0]      age;
  logic                  signCap;
  logic [SHIFT_BITS-1:0] sdHist;
  logic [SHIFT_BITS:0]   histAll;
  logic                  edgeNow;
  logic                  steady;

  assign histAll = {sdHist, sdIn};
  assign edgeNow = (wsIn != prevWs);
  assign steady  = armed && !edgeNow;

  // Independent model of slot age, captured sign bit and delayed input.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevWs  <= 1'b0;
      armed   <= 1'b0;
      age     <= '0;
      signCap <= 1'b0;
      sdHist  <= '0;
    end else begin
      prevWs <= wsIn;
      sdHist <= histAll[SHIFT_BITS-1:0];
      if (edgeNow) begin
        age   <= AGE_W'(1);
        armed <= 1'b1;
      end else if (age != AGE_W'(AGE_MAX)) begin
        age <= age + AGE_W'(1);
      end
      if (steady && age == AGE_W'(1)) begin
        signCap <= sdIn;
      end
    end
  end

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(strobe.tapSel)); // R4

  AST_MSB_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (steady && age == AGE_W'(1)) |-> (sdOut == sdIn)); // R2

  AST_SIGN_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (steady && age >= AGE_W'(2) && age <= AGE_W'(SHIFT_BITS + 1)) |-> (sdOut == signCap)); // R3

  AST_MAG_DELAY: assert property (@(posedge clk) disable iff (rst)
    (steady && age == AGE_W'(AGE_MAX)) |-> (sdOut == sdHist[SHIFT_BITS-1])); // R4

  AST_EDGE_PASS: assert property (@(posedge clk) disable iff (rst)
    (armed && edgeNow) |-> (sdOut == sdIn)); // R6

endmodule

bind i2s_attn i2s_attn_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .wsIn   (wsIn),
  .sdIn   (sdIn),
  .sdOut  (sdOut),
  .strobe (strobe)
);

// File: tb/i2s_attn_tb_top.sv
module i2s_attn_tb_top;
  import i2s_attn_pkg::*;

  localparam int SAMPLE_W = 16;
  localparam int SLOT_W   = 32;

  logic clk = 1'b0;
  logic rst, wsIn, sdIn;
  logic wsOut, sdOut;
  int   nChecks = 0;
  int   nFails  = 0;
  logic done = 1'b0;
  logic chanWs = 1'b1;

  always #2 clk = ~clk;

  i2s_attn dut_i (
    .clk   (clk),
    .rst   (rst),
    .wsIn  (wsIn),
    .sdIn  (sdIn),
    .wsOut (wsOut),
    .sdOut (sdOut)
  );

  // R9: arithmetic shift of the slot word, placed one clock after the edge.
  function automatic logic [SLOT_W-1:0] expSlot(input logic [SAMPLE_W-1:0] s);
    logic signed [SLOT_W-1:0] v;
    v = {s, {(SLOT_W-SAMPLE_W){1'b0}}};
    v = v >>> SHIFT_BITS;
    return {1'b0, v[SLOT_W-1:1]};
  endfunction

  task automatic sendSlot(input logic [SAMPLE_W-1:0] s);
    logic [SLOT_W-1:0] got, want;
    logic wsBad;
    wsBad = 1'b0;
    got = '0;
    for (int t = 0; t < SLOT_W; t++) begin
      @(negedge clk);
      wsIn = chanWs;
      sdIn = (t >= 1 && t <= SAMPLE_W) ? s[SAMPLE_W-t] : 1'b0;
      #1;
      got[SLOT_W-1-t] = sdOut;
      if (wsOut !== wsIn) wsBad = 1'b1;
    end
    want = expSlot(s);
    nChecks++;
    if (got !== want) begin
      nFails++;
      $display("FAIL R2 R3 R4 R5 R6 R7 R9 ws=%0b sample=%h actual=%h expected=%h",
               chanWs, s, got, want);
    end
    nChecks++;
    if (wsBad) begin
      nFails++;
      $display("FAIL R1 ws=%0b actual=mismatch expected=wsOut equal wsIn", chanWs);
    end
    chanWs = ~chanWs;
  endtask

  task automatic checkBit(input logic want, input string tag);
    nChecks++;
    if (sdOut !== want) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, sdOut, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [SAMPLE_W-1:0] corner [12];
    corner = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h0002,
               16'h0003, 16'hFFFE, 16'hFFFD, 16'hFFFC, 16'h4000, 16'hC000};
    rst = 1'b1; wsIn = 1'b0; sdIn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    checkBit(1'b0, "R8 in reset");
    nChecks++;
    if (wsOut !== wsIn) begin
      nFails++;
      $display("FAIL R1 in reset actual=%b expected=%b", wsOut, wsIn);
    end
    @(negedge clk); rst = 1'b0;

    // R8: fill the delay stages with ones, then reset and look at the deepest tap.
    repeat (4) begin @(negedge clk); sdIn = 1'b1; end
    @(negedge clk); rst = 1'b1; sdIn = 1'b0;
    @(negedge clk); rst = 1'b0; #1;
    checkBit(1'b0, "R8 first clock after reset");
    @(negedge clk); #1;
    checkBit(1'b0, "R8 second clock after reset");
    repeat (2) @(negedge clk);

    // R5 R7: each corner value on both channels.
    foreach (corner[i]) begin
      sendSlot(corner[i]);
      sendSlot(corner[i]);
    end
    // R4: walking ones and zeros move every bit through the delay boundary.
    for (int b = 0; b < SAMPLE_W; b++) begin
      sendSlot(16'(1) << b);
      sendSlot(~(16'(1) << b));
    end
    // R9: sweep of all upper-bit codes with varied low bits.
    for (int k = 0; k < 1024; k++) begin
      sendSlot(16'((k * 64) + ((k * 37) % 64)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule